// File: doc/BRIEF.md
# Mailbox Doorbell Command Interface

This block is the host-facing register window of a device command mailbox. A host writes a command word (opcode, command set, input length) and an input payload. It then sets a doorbell bit in the control register. The block takes a snapshot of the command. It streams the input payload words to an internal command handler and wipes the whole payload buffer. After that it raises a request to the handler and waits for a completion that carries a return code, an output length and a flag saying that a background job was started.

On completion the block rewrites the status word and the command word, keeping the command set and opcode. The handler's output words are already in the payload buffer. The block then drops the doorbell, and the host polls the doorbell to learn that the command is done. Two live status sources are also visible to the host: a background-operation status word built from handler inputs, and a status-word read that clears the background bit once progress is reported.

Host accesses are aligned, 1, 2, 4 or 8 bytes wide. Write data and read data are both right-aligned on the 64-bit bus. Read data returns one cycle after the request.

Top module: `mbx_doorbell_if`

## Requirements
- R1: After reset the doorbell, command word and status word read as zero. The 32-bit capability word at offset 0x00 reads 0x4CB: payload size shift 11 in bits [4:0], background interrupt support in bit 6, interrupt vector 9 in bits [10:7].
- R2: The capability word is read-only. A write of any size at offset 0x00 leaves it unchanged.
- R3: The control word at offset 0x04 is written only by a 4-byte access, and its bit 0 is the doorbell. Writes of other sizes do not change it. A 4-byte write with bit 0 set, made while the doorbell is clear, starts a command.
- R4: The command word at offset 0x08 accepts only 8-byte writes. Its layout is opcode [7:0], command set [15:8] and length [36:16]. A 4-byte write at 0x08 is ignored.
- R5: The status word at offset 0x10 holds the background flag in bit 0 and the return code in [47:32]. Host writes to it are ignored.
- R6: Payload bytes start at offset 0x20. Writes of any size there store the bytes in little-endian order, and reads return them.
- R7: When a command starts, the block presents input words 0 to ceil(length/8)-1 to the handler in ascending order. It zeroes the whole payload buffer and then requests the handler with the latched command set, opcode and length.
- R8: When the handler is done, the status word holds the background flag and return code. The command word keeps its set and opcode and carries the output length. The doorbell clears. The payload holds the handler's words, and every other word is zero.
- R9: While the doorbell is set, host writes to the payload, command and control words are ignored, and the doorbell stays set.
- R10: An input length above 2048 skips the handler. The command completes with return code 0x0002, background flag 0 and output length 0, and the payload is left untouched.
- R11: An 8-byte read at offset 0x18 returns the live background opcode in [15:0], the percentage in [22:16] and the return code in [47:32].
- R12: An 8-byte read of the status word while the background percentage is nonzero returns bit 0 cleared and leaves it cleared. With a percentage of zero the bit is kept.
- R13: A read returns the addressed bytes right-aligned, with the upper bytes zero. The data is valid with the response strobe one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hreq | input | 1 | Host access request |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| haddr | input | ADDR_W | Byte address within the window |
| hwdata | input | 64 | Right-aligned write data |
| hrvalid | output | 1 | Read response strobe |
| hrdata | output | 64 | Right-aligned read data |
| hnd_in_valid | output | 1 | Input payload word valid |
| hnd_in_idx | output | IDX_W | Input payload word index |
| hnd_in_data | output | 64 | Input payload word |
| hnd_req | output | 1 | Handler request, held until done |
| hnd_set | output | 8 | Latched command set |
| hnd_op | output | 8 | Latched opcode |
| hnd_len | output | 21 | Latched input length |
| hnd_wr_en | input | 1 | Handler output word write |
| hnd_wr_idx | input | IDX_W | Handler output word index |
| hnd_wr_data | input | 64 | Handler output word |
| hnd_done | input | 1 | Handler completion |
| hnd_rc | input | 16 | Handler return code |
| hnd_len_out | input | 21 | Handler output length |
| hnd_bg_start | input | 1 | Background job started |
| bg_op | input | 16 | Live background opcode |
| bg_pct | input | 7 | Live background percentage |
| bg_rc | input | 16 | Live background return code |

## Verification
A wrong sequencer state shows up at the doorbell. If it stays set too long, polling never ends and the watchdog fires. If it falls too early, the status and command words are stale at the first poll that sees it clear. A faulty wipe or stream shows a nonzero payload word, or a wrong captured input word, at the readback that directly follows completion. A broken write gate during a busy command shows in the doorbell read taken a few cycles after the poke, and in the poked payload word after completion.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int LEN_W = 21;
    localparam int RC_W  = 16;

    localparam logic [5:0] OFS_CAP  = 6'h00;
    localparam logic [5:0] OFS_CTRL = 6'h04;
    localparam logic [5:0] OFS_CMD  = 6'h08;
    localparam logic [5:0] OFS_STS  = 6'h10;
    localparam logic [5:0] OFS_BGS  = 6'h18;
    localparam logic [5:0] OFS_PLD  = 6'h20;

    localparam logic [RC_W-1:0] RC_INTERNAL = 16'h0002;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2,
        SZ_8 = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RUN,
        ST_FAIL
    } mbx_state_e;

    typedef struct packed {
        logic [7:0]       cset;
        logic [7:0]       op;
        logic [LEN_W-1:0] len;
    } mbx_cmd_t;

    function automatic logic [63:0] cmd_to_word(mbx_cmd_t c);
        return {27'd0, c.len, c.cset, c.op};
    endfunction

    function automatic mbx_cmd_t word_to_cmd(logic [63:0] w);
        mbx_cmd_t c;
        c.op   = w[7:0];
        c.cset = w[15:8];
        c.len  = w[36:16];
        return c;
    endfunction

    function automatic logic [63:0] sts_pack(logic bg, logic [RC_W-1:0] rc);
        return {16'd0, rc, 31'd0, bg};
    endfunction

    function automatic logic [63:0] bgs_pack(logic [15:0] op, logic [6:0] pct,
                                             logic [RC_W-1:0] rc);
        return {16'd0, rc, 9'd0, pct, op};
    endfunction

    function automatic logic [31:0] cap_pack(logic [4:0] shift, logic bg_irq,
                                             logic [3:0] vec);
        return {21'd0, vec, bg_irq, 1'b0, shift};
    endfunction

    function automatic logic [7:0] size_be(logic [1:0] s);
        case (s)
            SZ_1:    return 8'h01;
            SZ_2:    return 8'h03;
            SZ_4:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] size_mask(logic [1:0] s);
        logic [7:0]  be;
        logic [63:0] m;
        be = size_be(s);
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/mbx_payload_buf.sv
module mbx_payload_buf #(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wbe,
    input  logic [63:0]      wdata,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [63:0]      ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [63:0]      rb_data
);

    for (genvar b = 0; b < 8; b++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[b]) lane_mem[widx] <= wdata[b*8 +: 8];
        end

        assign ra_data[b*8 +: 8] = lane_mem[ra_idx];
        assign rb_data[b*8 +: 8] = lane_mem[rb_idx];
    end

endmodule

// File: rtl/mbx_door_fsm.sv
module mbx_door_fsm
    import mbx_pkg::*;
#(
    parameter int DEPTH         = 256,
    parameter int IDX_W         = 8,
    parameter int PAYLOAD_BYTES = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             ctrl_db,
    input  logic             cmd_wr,
    input  logic [63:0]      cmd_wdata,
    input  logic             sts_clr,
    input  logic             hnd_done,
    input  logic [RC_W-1:0]  hnd_rc,
    input  logic [LEN_W-1:0] hnd_len_out,
    input  logic             hnd_bg_start,
    output logic             doorbell,
    output logic [63:0]      cmd_w,
    output logic [63:0]      sts_w,
    output logic             scan_active,
    output logic [IDX_W-1:0] scan_idx,
    output logic             scan_in_word,
    output logic             run_active,
    output mbx_cmd_t         lat_cmd
);

    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(PAYLOAD_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DEPTH - 1);

    mbx_state_e       state;
    mbx_cmd_t         cur_cmd;
    logic [LEN_W-1:0] in_words;

    assign cur_cmd      = word_to_cmd(cmd_w);
    assign in_words     = (lat_cmd.len + LEN_W'(7)) >> 3;
    assign scan_active  = (state == ST_SCAN);
    assign run_active   = (state == ST_RUN);
    assign scan_in_word = scan_active && (LEN_W'(scan_idx) < in_words);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            doorbell <= 1'b0;
            cmd_w    <= '0;
            sts_w    <= '0;
            scan_idx <= '0;
            lat_cmd  <= '0;
        end else begin
            if (sts_clr) sts_w[0] <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_wr) cmd_w <= cmd_wdata;
                    if (ctrl_wr && ctrl_db) begin
                        doorbell <= 1'b1;
                        lat_cmd  <= cur_cmd;
                        scan_idx <= '0;
                        state    <= (cur_cmd.len > LEN_LIMIT) ? ST_FAIL : ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    scan_idx <= scan_idx + 1'b1;
                    if (scan_idx == LAST_IDX) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (hnd_done) begin
                        sts_w    <= sts_pack(hnd_bg_start, hnd_rc);
                        cmd_w    <= cmd_to_word('{cset: lat_cmd.cset, op: lat_cmd.op,
                                                  len: hnd_len_out});
                        doorbell <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                default: begin
                    sts_w    <= sts_pack(1'b0, RC_INTERNAL);
                    cmd_w    <= cmd_to_word('{cset: lat_cmd.cset, op: lat_cmd.op,
                                              len: '0});
                    doorbell <= 1'b0;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/mbx_doorbell_if.sv
module mbx_doorbell_if
    import mbx_pkg::*;
#(
    parameter int PAYLOAD_SHIFT = 11,
    parameter int MSI_VEC       = 9,
    parameter int IDX_W         = PAYLOAD_SHIFT - 3,
    parameter int ADDR_W        = $clog2(32 + (1 << PAYLOAD_SHIFT))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hreq,
    input  logic              hwrite,
    input  logic [1:0]        hsize,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [63:0]       hwdata,
    output logic              hrvalid,
    output logic [63:0]       hrdata,
    output logic              hnd_in_valid,
    output logic [IDX_W-1:0]  hnd_in_idx,
    output logic [63:0]       hnd_in_data,
    output logic              hnd_req,
    output logic [7:0]        hnd_set,
    output logic [7:0]        hnd_op,
    output logic [20:0]       hnd_len,
    input  logic              hnd_wr_en,
    input  logic [IDX_W-1:0]  hnd_wr_idx,
    input  logic [63:0]       hnd_wr_data,
    input  logic              hnd_done,
    input  logic [15:0]       hnd_rc,
    input  logic [20:0]       hnd_len_out,
    input  logic              hnd_bg_start,
    input  logic [15:0]       bg_op,
    input  logic [6:0]        bg_pct,
    input  logic [15:0]       bg_rc
);

    localparam int PAYLOAD_BYTES = 1 << PAYLOAD_SHIFT;
    localparam int DEPTH         = PAYLOAD_BYTES / 8;
    localparam logic [31:0] CAP_WORD =
        cap_pack(5'(PAYLOAD_SHIFT), 1'b1, 4'(MSI_VEC));

    // ---------------- address decode ----------------
    logic              wr_acc, rd_acc, in_regs, in_pld;
    logic [ADDR_W-1:0] pld_off;
    logic [IDX_W-1:0]  pld_idx;
    logic [2:0]        lane;

    assign wr_acc  = hreq && hwrite;
    assign rd_acc  = hreq && !hwrite;
    assign in_regs = haddr < ADDR_W'(OFS_PLD);
    assign pld_off = haddr - ADDR_W'(OFS_PLD);
    assign in_pld  = !in_regs && (pld_off < ADDR_W'(PAYLOAD_BYTES));
    assign pld_idx = pld_off[IDX_W+2:3];
    assign lane    = haddr[2:0];

    logic ctrl_wr, cmd_wr, sts_clr;
    assign ctrl_wr = wr_acc && hsize == SZ_4 && haddr == ADDR_W'(OFS_CTRL);
    assign cmd_wr  = wr_acc && hsize == SZ_8 && haddr == ADDR_W'(OFS_CMD);
    assign sts_clr = rd_acc && hsize == SZ_8 && haddr == ADDR_W'(OFS_STS)
                     && bg_pct != 7'd0;

    // ---------------- sequencer ----------------
    logic             doorbell, scan_active, scan_in_word, run_active;
    logic [IDX_W-1:0] scan_idx;
    logic [63:0]      cmd_w, sts_w;
    mbx_cmd_t         lat_cmd;

    mbx_door_fsm #(
        .DEPTH        (DEPTH),
        .IDX_W        (IDX_W),
        .PAYLOAD_BYTES(PAYLOAD_BYTES)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .ctrl_db     (hwdata[0]),
        .cmd_wr      (cmd_wr),
        .cmd_wdata   (hwdata),
        .sts_clr     (sts_clr),
        .hnd_done    (hnd_done),
        .hnd_rc      (hnd_rc),
        .hnd_len_out (hnd_len_out),
        .hnd_bg_start(hnd_bg_start),
        .doorbell    (doorbell),
        .cmd_w       (cmd_w),
        .sts_w       (sts_w),
        .scan_active (scan_active),
        .scan_idx    (scan_idx),
        .scan_in_word(scan_in_word),
        .run_active  (run_active),
        .lat_cmd     (lat_cmd)
    );

    // ---------------- payload write arbitration ----------------
    logic             buf_we;
    logic [IDX_W-1:0] buf_widx;
    logic [7:0]       buf_be;
    logic [63:0]      buf_wdata, pld_rd, scan_rd;

    always_comb begin
        buf_we    = 1'b0;
        buf_widx  = pld_idx;
        buf_be    = size_be(hsize) << lane;
        buf_wdata = hwdata << {lane, 3'b000};
        if (scan_active) begin
            buf_we    = 1'b1;
            buf_widx  = scan_idx;
            buf_be    = 8'hFF;
            buf_wdata = '0;
        end else if (run_active && hnd_wr_en) begin
            buf_we    = 1'b1;
            buf_widx  = hnd_wr_idx;
            buf_be    = 8'hFF;
            buf_wdata = hnd_wr_data;
        end else if (wr_acc && in_pld && !doorbell) begin
            buf_we = 1'b1;
        end
    end

    mbx_payload_buf #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_buf (
        .clk    (clk),
        .we     (buf_we),
        .widx   (buf_widx),
        .wbe    (buf_be),
        .wdata  (buf_wdata),
        .ra_idx (pld_idx),
        .ra_data(pld_rd),
        .rb_idx (scan_idx),
        .rb_data(scan_rd)
    );

    // ---------------- read path ----------------
    logic [63:0] sts_view, reg_word, sel_word;

    assign sts_view = sts_clr ? {sts_w[63:1], 1'b0} : sts_w;

    always_comb begin
        case (haddr[4:3])
            2'd0:    reg_word = {31'd0, doorbell, CAP_WORD};
            2'd1:    reg_word = cmd_w;
            2'd2:    reg_word = sts_view;
            default: reg_word = bgs_pack(bg_op, bg_pct, bg_rc);
        endcase
        if (in_regs)     sel_word = reg_word;
        else if (in_pld) sel_word = pld_rd;
        else             sel_word = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hrvalid <= 1'b0;
            hrdata  <= '0;
        end else begin
            hrvalid <= rd_acc;
            if (rd_acc) hrdata <= (sel_word >> {lane, 3'b000}) & size_mask(hsize);
        end
    end

    // ---------------- handler side ----------------
    assign hnd_in_valid = scan_in_word;
    assign hnd_in_idx   = scan_idx;
    assign hnd_in_data  = scan_rd;
    assign hnd_req      = run_active;
    assign hnd_set      = lat_cmd.cset;
    assign hnd_op       = lat_cmd.op;
    assign hnd_len      = lat_cmd.len;

endmodule

module mbx_doorbell_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              hreq,
    input logic              hwrite,
    input logic [1:0]        hsize,
    input logic [ADDR_W-1:0] haddr,
    input logic              hrvalid,
    input logic [63:0]       hrdata,
    input logic              hnd_in_valid,
    input logic              hnd_req,
    input logic              hnd_done,
    input logic [6:0]        bg_pct,
    input logic              doorbell,
    input logic [63:0]       sts_w,
    input logic [63:0]       cmd_w
);

    // R7
    req_needs_door_chk: assert property (@(posedge clk) disable iff (rst)
        hnd_req |-> doorbell);

    // R7
    stream_before_req_chk: assert property (@(posedge clk) disable iff (rst)
        hnd_in_valid |-> (doorbell && !hnd_req));

    // R8
    done_clears_door_chk: assert property (@(posedge clk) disable iff (rst)
        (hnd_req && hnd_done) |=> !doorbell && !hnd_req);

    // R5
    sts_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (hreq && hwrite && haddr == ADDR_W'(16) && !doorbell) |=> $stable(sts_w));

    // R9
    busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hreq && hwrite && haddr == ADDR_W'(8) && doorbell && !$rose(doorbell)
         && !(hnd_req && hnd_done)) |=> $stable(cmd_w));

    // R12
    sts_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hreq && !hwrite && hsize == 2'd3 && haddr == ADDR_W'(16)
         && bg_pct != 7'd0 && !doorbell) |=> (hrvalid && !hrdata[0] && !sts_w[0]));

    // R13
    read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (hreq && !hwrite) |=> hrvalid);

endmodule

bind mbx_doorbell_if mbx_doorbell_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hreq        (hreq),
    .hwrite      (hwrite),
    .hsize       (hsize),
    .haddr       (haddr),
    .hrvalid     (hrvalid),
    .hrdata      (hrdata),
    .hnd_in_valid(hnd_in_valid),
    .hnd_req     (hnd_req),
    .hnd_done    (hnd_done),
    .bg_pct      (bg_pct),
    .doorbell    (doorbell),
    .sts_w       (sts_w),
    .cmd_w       (cmd_w)
);

// File: tb/mbx_doorbell_if_tb.sv
module mbx_doorbell_if_tb;

    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hreq = 1'b0, hwrite = 1'b0;
    logic [1:0]  hsize = 2'd0;
    logic [AW-1:0] haddr = '0;
    logic [63:0] hwdata = '0;
    logic        hrvalid;
    logic [63:0] hrdata;
    logic        hnd_in_valid;
    logic [7:0]  hnd_in_idx;
    logic [63:0] hnd_in_data;
    logic        hnd_req;
    logic [7:0]  hnd_set, hnd_op;
    logic [20:0] hnd_len;
    logic        hnd_wr_en = 1'b0;
    logic [7:0]  hnd_wr_idx = '0;
    logic [63:0] hnd_wr_data = '0;
    logic        hnd_done = 1'b0;
    logic [15:0] hnd_rc = '0;
    logic [20:0] hnd_len_out = '0;
    logic        hnd_bg_start = 1'b0;
    logic [15:0] bg_op = '0;
    logic [6:0]  bg_pct = '0;
    logic [15:0] bg_rc = '0;

    always #10 clk = ~clk;

    mbx_doorbell_if u_dut (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_out(logic [7:0] op, int i);
        return {op, 8'hA5, 16'(i), 32'hC0DE_0000 ^ 32'(i * 7)};
    endfunction

    function automatic logic [63:0] mask_of(int sz);
        return (sz == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (sz * 8)) - 1);
    endfunction

    function automatic logic [1:0] enc(int sz);
        return (sz == 1) ? 2'd0 : (sz == 2) ? 2'd1 : (sz == 4) ? 2'd2 : 2'd3;
    endfunction

    task automatic bus_wr(int a, int sz, logic [63:0] d);
        @(negedge clk);
        hreq = 1; hwrite = 1; haddr = AW'(a); hsize = enc(sz); hwdata = d;
        @(negedge clk);
        hreq = 0; hwrite = 0;
    endtask

    task automatic bus_rd(int a, int sz, output logic [63:0] d);
        @(negedge clk);
        hreq = 1; hwrite = 0; haddr = AW'(a); hsize = enc(sz);
        @(negedge clk);
        hreq = 0;
        if (!hrvalid) chk("R13 strobe", {63'd0, hrvalid}, 64'd1);
        d = hrdata;
    endtask

    // ---- handler stub ----
    int          stub_calls = 0, stub_out_len = 0, stub_delay = 2;
    logic [15:0] stub_rc = '0;
    logic        stub_bg = 1'b0;
    logic [7:0]  got_set, got_op;
    logic [20:0] got_len;
    logic [63:0] in_seen [256];
    int          in_cnt = 0, in_order_bad = 0, last_idx = -1;

    initial begin
        forever begin
            @(negedge clk);
            if (hnd_in_valid) begin
                in_seen[hnd_in_idx] = hnd_in_data;
                if (int'(hnd_in_idx) != last_idx + 1) in_order_bad++;
                last_idx = int'(hnd_in_idx);
                in_cnt++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (hnd_req) begin
                stub_calls++;
                got_set = hnd_set; got_op = hnd_op; got_len = hnd_len;
                repeat (stub_delay) @(negedge clk);
                for (int i = 0; i < (stub_out_len + 7) / 8; i++) begin
                    hnd_wr_en = 1; hnd_wr_idx = 8'(i); hnd_wr_data = exp_out(got_op, i);
                    @(negedge clk);
                end
                hnd_wr_en = 0;
                hnd_done = 1; hnd_rc = stub_rc; hnd_len_out = 21'(stub_out_len);
                hnd_bg_start = stub_bg;
                @(negedge clk);
                hnd_done = 0;
            end
        end
    end

    logic [63:0] pw [256];

    task automatic wait_door(output logic [63:0] v);
        int guard;
        guard = 0;
        do begin
            bus_rd(4, 4, v);
            guard++;
        end while (v[0] && guard < 2000);
    endtask

    task automatic run_cmd(logic [7:0] cs, logic [7:0] op, int len, int olen,
                           logic [15:0] rc, logic bg, bit poke);
        logic [63:0] v;
        int nw, onw, bad, calls0;
        nw = (len + 7) / 8;
        onw = (olen + 7) / 8;
        for (int i = 0; i < nw; i++) begin
            pw[i] = {$urandom, $urandom};
            bus_wr(32 + 8 * i, 8, pw[i]);
        end
        stub_out_len = olen; stub_rc = rc; stub_bg = bg;
        stub_delay = poke ? 24 : 2;
        in_cnt = 0; last_idx = -1; in_order_bad = 0; calls0 = stub_calls;
        bus_wr(8, 8, {27'd0, 21'(len), cs, op});
        bus_wr(4, 4, 64'd1);
        if (poke) begin
            wait (hnd_req);
            bus_wr(8, 8, 64'hFFFF_FFFF_FFFF_FFFF);
            bus_wr(32 + 8 * 200, 8, 64'hDEAD_BEEF_0000_0001);
            bus_wr(4, 4, 64'd0);
            bus_rd(4, 4, v);
            chk("R9 doorbell held", v, 64'd1);
        end
        wait_door(v);
        chk("R8 doorbell cleared", v, 64'd0);
        chk("R7 handler calls", 64'(stub_calls - calls0), 64'd1);
        chk("R7 latched command", {27'd0, got_len, got_set, got_op},
            {27'd0, 21'(len), cs, op});
        chk("R7 input word count", 64'(in_cnt), 64'(nw));
        chk("R7 input order", 64'(in_order_bad), 64'd0);
        bad = 0;
        for (int i = 0; i < nw; i++) if (in_seen[i] !== pw[i]) bad++;
        chk("R7 input words", 64'(bad), 64'd0);
        bus_rd(16, 8, v);
        chk("R8 status", v, {16'd0, rc, 31'd0, bg});
        bus_rd(8, 8, v);
        chk("R8 command word", v, {27'd0, 21'(olen), cs, op});
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            bus_rd(32 + 8 * i, 8, v);
            if (v !== ((i < onw) ? exp_out(op, i) : 64'd0)) bad++;
        end
        chk("R8 payload contents", 64'(bad), 64'd0);
        if (poke) begin
            bus_rd(32 + 8 * 200, 8, v);
            chk("R9 payload poke ignored", v, 64'd0);
        end
    endtask

    initial begin
        logic [63:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        bus_rd(0, 4, v);  chk("R1 capability", v, 64'h4CB);
        bus_rd(4, 4, v);  chk("R1 control", v, 64'd0);
        bus_rd(8, 8, v);  chk("R1 command", v, 64'd0);
        bus_rd(16, 8, v); chk("R1 status", v, 64'd0);

        // R2 capability read-only
        bus_wr(0, 4, 64'hFFFF_FFFF);
        bus_wr(0, 1, 64'h00);
        bus_wr(0, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_rd(0, 4, v);  chk("R2 capability unchanged", v, 64'h4CB);
        // R3 control only by 4-byte writes
        bus_rd(4, 4, v);  chk("R3 8-byte write missed doorbell", v, 64'd0);
        bus_wr(4, 2, 64'd1);
        bus_wr(4, 1, 64'd1);
        bus_rd(4, 4, v);  chk("R3 narrow control write ignored", v, 64'd0);
        chk("R3 no handler call", 64'(stub_calls), 64'd0);
        // R4 command word
        bus_wr(8, 8, 64'h0000_0012_3456_789A);
        bus_rd(8, 8, v);  chk("R4 command write", v, 64'h0000_0012_3456_789A);
        bus_wr(8, 4, 64'hFFFF_FFFF);
        bus_rd(8, 8, v);  chk("R4 4-byte write ignored", v, 64'h0000_0012_3456_789A);
        // R5 status write ignored
        bus_wr(16, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_rd(16, 8, v); chk("R5 status write ignored", v, 64'd0);

        // R6 payload byte lanes, R13 read sizes
        bus_wr(32 + 8, 8, 64'd0);
        bus_wr(32 + 8, 1, 64'hFF11);
        bus_wr(32 + 10, 2, 64'h2233);
        bus_wr(32 + 12, 4, 64'h4455_6677);
        bus_rd(32 + 8, 8, v);  chk("R6 payload mixed writes", v, 64'h4455_6677_2233_0011);
        bus_rd(32 + 11, 1, v); chk("R13 byte read", v, 64'h22);
        bus_rd(32 + 12, 2, v); chk("R13 half read", v, 64'h6677);
        bus_rd(9, 1, v);       chk("R13 command byte", v, 64'h78);
        bus_rd(0, 2, v);       chk("R13 capability half", v, 64'h04CB);

        // R7 R8 directed: zero length, and maximum length
        run_cmd(8'h01, 8'h02, 0, 16, 16'h0000, 1'b0, 0);
        run_cmd(8'h44, 8'h03, 2048, 2048, 16'h0007, 1'b1, 0);

        // R7 R8 random commands
        for (int k = 0; k < 5; k++) begin
            run_cmd(8'($urandom), 8'($urandom), int'($urandom_range(0, 2048)),
                    int'($urandom_range(0, 1600)), 16'($urandom), 1'($urandom), 0);
        end

        // R9 writes while busy
        run_cmd(8'h5A, 8'hC3, 40, 24, 16'h0001, 1'b0, 1);

        // R10 oversize input
        begin
            int calls0;
            calls0 = stub_calls;
            bus_wr(32 + 24, 8, 64'h1234_5678_9ABC_DEF0);
            bus_wr(8, 8, {27'd0, 21'd2049, 8'h07, 8'h09});
            bus_wr(4, 4, 64'd1);
            wait_door(v);
            chk("R10 doorbell cleared", v, 64'd0);
            chk("R10 handler skipped", 64'(stub_calls - calls0), 64'd0);
            bus_rd(16, 8, v); chk("R10 status", v, {16'd0, 16'h0002, 32'd0});
            bus_rd(8, 8, v);  chk("R10 command word", v, {48'd0, 8'h07, 8'h09});
            bus_rd(32 + 24, 8, v); chk("R10 payload kept", v, 64'h1234_5678_9ABC_DEF0);
        end

        // R11 background status word
        for (int k = 0; k < 3; k++) begin
            bg_op = 16'($urandom); bg_pct = 7'($urandom_range(0, 100)); bg_rc = 16'($urandom);
            bus_rd(24, 8, v);
            chk("R11 background status", v, {16'd0, bg_rc, 9'd0, bg_pct, bg_op});
        end

        // R12 status bg bit clearing
        bg_pct = 0;
        run_cmd(8'h10, 8'h20, 8, 8, 16'h0000, 1'b1, 0);
        bus_rd(16, 8, v); chk("R12 bit kept at zero percent", v, 64'd1);
        bg_pct = 7'd5;
        bus_rd(16, 4, v); chk("R12 narrow read no clear", v, 64'd1);
        bus_rd(16, 8, v); chk("R12 cleared on read", v, 64'd0);
        bg_pct = 0;
        bus_rd(16, 8, v); chk("R12 stays cleared", v, 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule